// File: doc/BRIEF.md
# DAC Boot Command Sequencer

This block is the host side of a serial link to a precision voltage-output DAC. It drives the serial clock, an active-low frame select and the serial data line, and it samples the DAC's serial data output. A pulse on `start` makes it send a fixed run of six 24-bit frames. The frames do the following, in order: set up the control register, load a midscale code into the DAC register, program a full-scale clear code, fire a software clear, request a readback of the clear code, and send one no-operation frame. During that last frame the readback word is clocked in.

When the last frame has ended, the captured word is compared with the full-scale clear code that was written. The result appears on `err`, and `done` stays high until the next `start`. The serial clock runs at the system clock divided by `2*DIV_HALF`. With `DIV_HALF` = 2 and a 125 MHz system clock, the serial clock is 31.25 MHz, which is under the DAC's 35 MHz limit.

The sequencer states are SQ_IDLE, SQ_INIT, SQ_MIDSCALE, SQ_CLRCODE, SQ_SWCLEAR, SQ_RDCMD, SQ_RDNOP, SQ_CHECK and SQ_DONE. Their transitions are:
- SQ_IDLE and SQ_DONE go to SQ_INIT on `start`.
- Each frame state moves to the next frame state when its frame has completed.
- SQ_RDNOP goes to SQ_CHECK.
- SQ_CHECK goes to SQ_DONE in one cycle.

The frame engine has its own states: SH_IDLE, then alternating SH_LOW and SH_HIGH for each of the 24 bits, then SH_TAIL (half a clock period before select rises), then SH_GAP (select held high), and back to SH_IDLE.

Top module: `dac_boot_seq`

## Requirements
- R1: While reset is held: `sync_n` is 1, `sclk` is 0, `sdin` is 0, and `done`, `err` and `rdback` are all 0.
- R2: Each frame puts exactly 24 bits on `sdin`, MSB first, inside one low window of `sync_n`. `sclk` idles low, is low whenever `sync_n` is high, and gives exactly 24 falling edges per frame.
- R3: After `start`, the six frames are sent in this order: 0x200012, 0x180000, 0x3FFFFF, 0x400002, 0xB00000, 0x000000.
- R4: Every `sclk` high and low phase inside a frame lasts `DIV_HALF` clock cycles, including the phase between the fall of `sync_n` and the first rising edge, and the phase between the last falling edge and the rise of `sync_n`. `sdin` changes only on a rising `sclk` edge or at the fall of `sync_n`.
- R5: Between frames, `sync_n` stays high for at least `4*DIV_HALF` clock cycles, which is two `sclk` periods.
- R6: During the no-operation frame, `sdo` is sampled on each falling `sclk` edge, MSB first. The 24-bit result appears on `rdback` when `done` rises.
- R7: `done` rises only after the sixth frame has ended, with `sync_n` high. At that point `err` is 1 exactly when `rdback` differs from 0x3FFFFF. `done`, `err` and `rdback` then hold, and no further frame is sent, until the next `start`.
- R8: A `start` pulse while a sequence is running is ignored, and the run still sends exactly six frames. A `start` pulse while idle or done begins a new sequence and clears `done` and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to run the boot sequence |
| sdo | input | 1 | Serial data from the DAC |
| sclk | output | 1 | Serial clock to the DAC |
| sync_n | output | 1 | Active-low frame select |
| sdin | output | 1 | Serial data to the DAC |
| done | output | 1 | Sequence finished and readback checked |
| err | output | 1 | Readback did not match the full-scale clear code |
| rdback | output | 24 | Word captured during the no-operation frame |

## Verification
Suppose the sequencer state is wrong, for example a skipped or repeated frame state. That fault appears on the serial pins within one frame time, about `50*DIV_HALF` cycles: a frame word is out of order, or the frame count at `done` is not six. If the frame engine's bit counter or half-period pacing is off, the fault appears on the very next `sclk` edge as a phase of the wrong length or a frame with a count other than 24 bits. A capture or compare fault reaches only `rdback` and `err`, so the bench drives readback words that differ from the good one in the top bit, the bottom bit or in random bits, and compares them in the cycle where `done` rises.

// File: rtl/dac_boot_pkg.sv
package dac_boot_pkg;

    localparam int FRAME_W = 24;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_INIT, SQ_MIDSCALE, SQ_CLRCODE, SQ_SWCLEAR,
        SQ_RDCMD, SQ_RDNOP, SQ_CHECK, SQ_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        SH_IDLE, SH_LOW, SH_HIGH, SH_TAIL, SH_GAP
    } sh_state_t;

    // control write: offset binary, output enabled, clamp released, buffer off
    localparam logic [FRAME_W-1:0] FR_CTRL_INIT = 24'h200012;
    localparam logic [FRAME_W-1:0] FR_MIDSCALE  = 24'h180000;
    localparam logic [FRAME_W-1:0] FR_CLRCODE   = 24'h3FFFFF;
    localparam logic [FRAME_W-1:0] FR_SWCLEAR   = 24'h400002;
    localparam logic [FRAME_W-1:0] FR_RDCMD     = 24'hB00000;
    localparam logic [FRAME_W-1:0] FR_NOP       = 24'h000000;
    localparam logic [FRAME_W-1:0] EXPECT_RB    = 24'h3FFFFF;

endpackage

// File: rtl/dac_sclk_tick.sv
module dac_sclk_tick #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (clear)       cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter
    import dac_boot_pkg::*;
#(
    parameter int DIV_HALF   = 2,
    parameter int GAP_HALVES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               go,
    input  logic [FRAME_W-1:0] word,
    input  logic               sdo,
    output logic               sclk_o,
    output logic               sync_n_o,
    output logic               sdin_o,
    output logic               idle,
    output logic               fdone,
    output logic [FRAME_W-1:0] rxword
);
    localparam int BW = $clog2(FRAME_W + 1);
    localparam int GW = $clog2(GAP_HALVES + 1);
    localparam logic [BW-1:0] LAST_FALL = BW'(FRAME_W - 1);
    localparam logic [GW-1:0] LAST_GAP  = GW'(GAP_HALVES - 1);

    sh_state_t st, st_nx;
    logic [FRAME_W-1:0] tx;
    logic [BW-1:0]      nfall;
    logic [GW-1:0]      gcnt;

    always_comb begin
        st_nx = st;
        unique case (st)
            SH_IDLE: if (go)   st_nx = SH_LOW;
            SH_LOW:  if (tick) st_nx = SH_HIGH;
            SH_HIGH: if (tick) st_nx = (nfall == LAST_FALL) ? SH_TAIL : SH_LOW;
            SH_TAIL: if (tick) st_nx = SH_GAP;
            SH_GAP:  if (tick && gcnt == LAST_GAP) st_nx = SH_IDLE;
            default: st_nx = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SH_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx <= '0; rxword <= '0; nfall <= '0; gcnt <= '0;
            sclk_o <= 1'b0; sync_n_o <= 1'b1; fdone <= 1'b0;
        end else begin
            fdone <= 1'b0;
            unique case (st)
                SH_IDLE: if (go) begin
                    tx <= word; sync_n_o <= 1'b0; nfall <= '0;
                end
                SH_LOW: if (tick) begin
                    sclk_o <= 1'b1;
                    if (nfall != '0) tx <= {tx[FRAME_W-2:0], 1'b0};
                end
                SH_HIGH: if (tick) begin
                    sclk_o <= 1'b0;
                    rxword <= {rxword[FRAME_W-2:0], sdo};
                    if (nfall != LAST_FALL) nfall <= nfall + 1'b1;
                end
                SH_TAIL: if (tick) begin
                    sync_n_o <= 1'b1; gcnt <= '0;
                end
                SH_GAP: if (tick) begin
                    if (gcnt == LAST_GAP) fdone <= 1'b1;
                    else                  gcnt  <= gcnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign sdin_o = tx[FRAME_W-1];
    assign idle   = (st == SH_IDLE);

    // checker counter: cycles spent with select high
    logic [15:0] hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              hi_cnt <= '1;
        else if (!sync_n_o)      hi_cnt <= '0;
        else if (hi_cnt != '1)   hi_cnt <= hi_cnt + 1'b1;
    end

    // R2
    sclk_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !sync_n_o);
    // R4
    sdin_stable_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> $stable(sdin_o));
    // R5
    select_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_n_o) |-> (hi_cnt >= 16'(GAP_HALVES * DIV_HALF)));
endmodule

// File: rtl/dac_boot_seq.sv
module dac_boot_seq
    import dac_boot_pkg::*;
#(
    parameter int DIV_HALF   = 2,
    parameter int GAP_HALVES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        sdo,
    output logic        sclk,
    output logic        sync_n,
    output logic        sdin,
    output logic        done,
    output logic        err,
    output logic [23:0] rdback
);
    seq_state_t state, state_nx;
    logic               tick, go, sh_idle, fdone, in_frame;
    logic [FRAME_W-1:0] word, rxword;

    dac_sclk_tick #(.DIV_HALF(DIV_HALF)) u_tick (
        .clk(clk), .rst_n(rst_n), .clear(go), .tick(tick)
    );

    dac_frame_shifter #(.DIV_HALF(DIV_HALF), .GAP_HALVES(GAP_HALVES)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .word(word), .sdo(sdo),
        .sclk_o(sclk), .sync_n_o(sync_n), .sdin_o(sdin),
        .idle(sh_idle), .fdone(fdone), .rxword(rxword)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE, SQ_DONE: if (start) state_nx = SQ_INIT;
            SQ_INIT:     if (fdone) state_nx = SQ_MIDSCALE;
            SQ_MIDSCALE: if (fdone) state_nx = SQ_CLRCODE;
            SQ_CLRCODE:  if (fdone) state_nx = SQ_SWCLEAR;
            SQ_SWCLEAR:  if (fdone) state_nx = SQ_RDCMD;
            SQ_RDCMD:    if (fdone) state_nx = SQ_RDNOP;
            SQ_RDNOP:    if (fdone) state_nx = SQ_CHECK;
            SQ_CHECK:    state_nx = SQ_DONE;
            default:     state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        in_frame = 1'b1;
        word     = FR_NOP;
        unique case (state)
            SQ_INIT:     word = FR_CTRL_INIT;
            SQ_MIDSCALE: word = FR_MIDSCALE;
            SQ_CLRCODE:  word = FR_CLRCODE;
            SQ_SWCLEAR:  word = FR_SWCLEAR;
            SQ_RDCMD:    word = FR_RDCMD;
            SQ_RDNOP:    word = FR_NOP;
            default:     in_frame = 1'b0;
        endcase
        go   = in_frame && sh_idle && !fdone;
        done = (state == SQ_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err <= 1'b0; rdback <= '0;
        end else begin
            if ((state == SQ_IDLE || state == SQ_DONE) && start) err <= 1'b0;
            if (state == SQ_RDNOP && fdone) rdback <= rxword;
            if (state == SQ_CHECK) err <= (rdback != EXPECT_RB);
        end
    end

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    // R7
    done_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sync_n);
    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && !fdone && start) |=> (state == $past(state)));
endmodule

// File: tb/dac_boot_seq_test.sv
module dac_boot_seq_test;
    localparam int DH   = 2;
    localparam int GAPH = 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdo = 1'b0;
    logic sclk, sync_n, sdin, done, err;
    logic [23:0] rdback;

    dac_boot_seq #(.DIV_HALF(DH), .GAP_HALVES(GAPH)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sdo(sdo),
        .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
        .done(done), .err(err), .rdback(rdback)
    );

    initial forever #4 clk = ~clk;

    int checks = 0, fails = 0;
    logic [23:0] cap_frames [0:7];
    int          cap_bits   [0:7];
    int fcount = 0, nbits = 0, run = 0, gap_run = 0, sdo_idx = 23;
    int timing_err = 0, sdin_err = 0, gap_err = 0, idle_err = 0;
    logic [23:0] resp = '0, cur = '0;
    logic p_sclk = 1'b0, p_sync = 1'b1, p_sdin = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_frame(input int i);
        case (i)
            0: return 24'h200012;
            1: return 24'h180000;
            2: return 24'h3FFFFF;
            3: return 24'h400002;
            4: return 24'hB00000;
            default: return 24'h000000;
        endcase
    endfunction

    // DAC model and pin monitor, sampled at the falling clock edge
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            run++; gap_run++;
            if (p_sync && !sync_n) begin
                if (fcount > 0 && gap_run < 4*DH) gap_err++;
                cur = '0; nbits = 0; run = 0; sdo_idx = 23;
                sdo = (fcount == 5) ? resp[23] : 1'b0;
            end else if (!sync_n) begin
                if (sclk !== p_sclk) begin
                    if (run != DH) timing_err++;
                    run = 0;
                    if (!sclk) begin
                        cur = {cur[22:0], sdin}; nbits++;
                    end else if (nbits > 0 && sdo_idx > 0) begin
                        sdo_idx--;
                        sdo = (fcount == 5) ? resp[sdo_idx] : 1'b0;
                    end
                end
                if (sdin !== p_sdin && !(sclk && !p_sclk)) sdin_err++;
            end else if (!p_sync && sync_n) begin
                if (run != DH) timing_err++;
                if (fcount < 8) begin
                    cap_frames[fcount] = cur; cap_bits[fcount] = nbits;
                end
                fcount++; gap_run = 0; sdo = 1'b0;
            end else if (sclk !== 1'b0) begin
                idle_err++;
            end
        end
        p_sclk = sclk; p_sync = sync_n; p_sdin = sdin;
    end

    task automatic run_seq(input logic [23:0] r, input bit poke);
        int waited = 0;
        resp = r; fcount = 0;
        timing_err = 0; sdin_err = 0; gap_err = 0; idle_err = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(done == 1'b0 && err == 1'b0, "R8", "done/err cleared on start",
              {30'd0, done, err}, 32'd0);
        if (poke) begin
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (!done && waited < 20000) begin
            @(negedge clk); waited++;
        end
        check(done == 1'b1, "R7", "done reached", {31'd0, done}, 32'd1);
        check(fcount == 6, poke ? "R8" : "R3", "frame count", fcount, 6);
        check(sync_n == 1'b1, "R7", "select high at done", {31'd0, sync_n}, 32'd1);
        for (int i = 0; i < 6; i++) begin
            check(cap_frames[i] == exp_frame(i), "R3", "frame word",
                  {8'd0, cap_frames[i]}, {8'd0, exp_frame(i)});
            check(cap_bits[i] == 24, "R2", "bits per frame", cap_bits[i], 24);
        end
        check(rdback == r, "R6", "readback word", {8'd0, rdback}, {8'd0, r});
        check(err == (r != 24'h3FFFFF), "R7", "error flag",
              {31'd0, err}, {31'd0, (r != 24'h3FFFFF)});
        check(timing_err == 0, "R4", "sclk phase length errors", timing_err, 0);
        check(sdin_err == 0, "R4", "sdin change off rising edge", sdin_err, 0);
        check(gap_err == 0, "R5", "short select gaps", gap_err, 0);
        check(idle_err == 0, "R2", "sclk high outside frame", idle_err, 0);
        repeat (40) @(negedge clk);
        check(done == 1'b1 && fcount == 6 && rdback == r, "R7", "hold after done",
              fcount, 6);
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        check(sync_n == 1'b1 && sclk == 1'b0 && sdin == 1'b0, "R1", "pins in reset",
              {29'd0, sync_n, sclk, sdin}, 32'h4);
        check(done == 1'b0 && err == 1'b0 && rdback == '0, "R1", "status in reset",
              {6'd0, done, err, rdback}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(sync_n == 1'b1 && done == 1'b0, "R1", "idle after reset",
              {30'd0, sync_n, done}, 32'h2);

        run_seq(24'h3FFFFF, 1'b0);
        run_seq(24'h000000, 1'b0);
        run_seq(24'h3FFFFE, 1'b0);
        run_seq(24'hBFFFFF, 1'b0);
        run_seq(24'h3FFFFF, 1'b1);
        for (int k = 0; k < 8; k++) begin
            logic [23:0] w;
            w = ($urandom % 2 == 0) ? 24'h3FFFFF : 24'($urandom);
            run_seq(w, k == 3);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule